// File: doc/BRIEF.md
# Descriptor-Chain Channel Engine

This block is one DMA channel that walks a linked list of descriptors held in memory. Software points the channel at the first descriptor and then adds credits to a counting semaphore. While credits remain and no error is latched, the engine reads a descriptor and copies its payload word by word from the source address to the destination address. Each word passes through a stub transform: a plain copy, or an XOR with a fixed constant when the descriptor enables the cipher. The engine then writes a completion value back into the descriptor. If the descriptor asks for it, the engine goes on to the next descriptor in the list.

Each descriptor says whether to consume a semaphore credit, whether to raise the done interrupt and whether to follow its next pointer. The engine checks some faults itself: a byte count that is not a whole number of 16-byte blocks, a key selection that cannot be satisfied, a chain that points to address zero, and credits arriving when no chain is loaded. On any of these it stops and latches a coded status. It then stays quiet until software clears that status through a clear-by-mask write. Memory is reached through a single-outstanding word request/acknowledge port.

Top module: `dchain_engine`

## Requirements
- R1: A descriptor occupies eight 32-bit words at byte offsets 0 next pointer, 4 control0, 8 control1, 12 source, 16 destination, 20 byte count, 24 payload pointer, 28 status. The engine reads words 0 to 6 starting at the current command pointer.
- R2: A configuration write with cfg_sel=1 adds cfg_wdata to the semaphore, which saturates at its maximum (255 by default). No descriptor is fetched while the semaphore is zero.
- R3: The semaphore drops by exactly one when a descriptor with control0 bit 1 completes. A descriptor without that bit leaves it unchanged, and the semaphore never drops at any other time.
- R4: Byte count / 4 words are moved from the source to the destination at increasing addresses. When control0 bit 5 is set, each word is XORed with XOR_KEY (default 32'h5A5AA5A5); when it is clear, the word is copied unchanged. A count of zero moves nothing.
- R5: On success the engine writes the value 1 to the status word (offset 28) of the descriptor.
- R6: If control0 bit 2 is set, the next descriptor is fetched from the next pointer. If it is clear, the chain ends. A nonzero semaphore with no chain loaded then latches error code 2 with flag bit 2. A cfg_sel=0 write of a command pointer loads a new chain.
- R7: A chained descriptor whose next pointer is zero is still completed and written back. The engine then latches error code 1 with flag bit 2.
- R8: A byte count whose low 4 bits are not zero latches error code 4 with flag bit 3. No data is moved and the status word is not written.
- R9: When control0 bit 5 and bit 10 are both set, and either bit 11 is set or control1 bits 15:8 are not 8'hFF, the engine latches error code 5 with flag bit 2 and moves no data. With key select 8'hFF the descriptor runs normally.
- R10: done_irq is high for one cycle after the status write of a descriptor whose control0 bit 0 is set, and for one cycle whenever an error is latched. Nothing else raises it.
- R11: The channel status shows the error code in bits 23:16 and the flags in bits 7:0. A cfg_sel=2 write clears the status bits set in cfg_wdata. While bits 23:16 are nonzero, the semaphore is not acted on.
- R12: A memory request holds mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack. Only one request is outstanding at a time.
- R13: After reset the channel status, the semaphore, done_irq, busy and mem_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 command pointer, 1 semaphore add, 2 status clear mask |
| cfg_wdata | input | DW | Configuration write data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |
| chan_status | output | DW | Error code 23:16, flags 7:0 |
| sem_count | output | SEM_W | Pending semaphore credits |
| busy | output | 1 | Engine is working on a descriptor |
| done_irq | output | 1 | One-cycle completion or error pulse |

## Verification
The assertions check the memory handshake (R12) on every cycle. They also check that the semaphore falls only at a write acknowledge and only one step at a time, that no request starts with a zero semaphore or a latched error, and that the error code always has one of the defined values. Data movement, the XOR transform, the status write-back values, the chain order and the exact error codes for each faulty descriptor can only be seen in the bench scenarios. The same holds for the effect of a partial status clear and the number of interrupt pulses. The bench compares memory contents and status against values it works out for itself.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_WBACK
  } eng_state_t;

  // word index inside a descriptor (the order is fixed by the memory image)
  localparam logic [2:0] W_NEXT = 3'd0;
  localparam logic [2:0] W_CTL0 = 3'd1;
  localparam logic [2:0] W_CTL1 = 3'd2;
  localparam logic [2:0] W_SRC  = 3'd3;
  localparam logic [2:0] W_DST  = 3'd4;
  localparam logic [2:0] W_LEN  = 3'd5;
  localparam logic [2:0] W_STAT = 3'd7;

  // control0 bit positions
  localparam int C0_IRQ    = 0;
  localparam int C0_SEMDEC = 1;
  localparam int C0_CHAIN  = 2;
  localparam int C0_CIPHER = 5;
  localparam int C0_OTK    = 10;
  localparam int C0_PLKEY  = 11;

  // error codes and flag masks
  localparam logic [7:0] ERR_NEXT_ZERO = 8'd1;
  localparam logic [7:0] ERR_NO_CHAIN  = 8'd2;
  localparam logic [7:0] ERR_PAYLOAD   = 8'd4;
  localparam logic [7:0] ERR_MODE      = 8'd5;
  localparam logic [7:0] FLG_SETUP     = 8'h04;
  localparam logic [7:0] FLG_PACKET    = 8'h08;

  // configuration selector values
  localparam logic [1:0] CFG_PTR = 2'd0;
  localparam logic [1:0] CFG_SEM = 2'd1;
  localparam logic [1:0] CFG_CLR = 2'd2;
endpackage

// File: rtl/dchain_sem.sv
module dchain_sem #(
  parameter int SEM_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_we,
  input  logic [DW-1:0]    add_val,
  input  logic             dec,
  output logic [SEM_W-1:0] count
);
  localparam int SUM_W = DW + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'((64'd1 << SEM_W) - 64'd1);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {{(SUM_W-SEM_W){1'b0}}, count};
    if (add_we) sum = sum + {1'b0, add_val};
    if (dec && (sum != '0)) sum = sum - SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= (sum > SAT) ? SAT[SEM_W-1:0] : sum[SEM_W-1:0];
  end
endmodule

// File: rtl/dchain_status.sv
module dchain_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raise,
  input  logic [7:0]    code,
  input  logic [7:0]    flags,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] status,
  output logic          err_active
);
  localparam int CODE_LSB = 16;

  logic [DW-1:0] nxt;

  always_comb begin
    nxt = status;
    if (clr_we) nxt = nxt & ~clr_mask;
    if (raise) begin
      nxt[CODE_LSB +: 8] = code;
      nxt[7:0]           = nxt[7:0] | flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= nxt;
  end

  assign err_active = |status[CODE_LSB +: 8];
endmodule

// File: rtl/dchain_xform.sv
module dchain_xform #(
  parameter int            DW  = 32,
  parameter logic [DW-1:0] KEY = '0
) (
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  assign dout = en ? (din ^ KEY) : din;
endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
  import dchain_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            SEM_W     = 8,
  parameter int            BLK_BYTES = 16,
  parameter logic [DW-1:0] XOR_KEY   = 32'h5A5A_A5A5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    chan_status,
  output logic [SEM_W-1:0] sem_count,
  output logic             busy,
  output logic             done_irq
);
  localparam int BPW         = DW / 8;
  localparam int WORD_SHIFT  = $clog2(BPW);
  localparam int BLK_BITS    = $clog2(BLK_BYTES);
  localparam int FETCH_WORDS = int'(W_STAT);
  localparam int WB_OFS      = int'(W_STAT) * BPW;

  eng_state_t    state;
  logic [AW-1:0] cur_ptr;
  logic          chain_ok;
  logic [2:0]    widx;
  logic [DW-1:0] remain;
  logic [AW-1:0] offs;
  logic [DW-1:0] desc_q [FETCH_WORDS];

  logic          err_active;
  logic          err_raise;
  logic [7:0]    err_code;
  logic [7:0]    err_flags;
  logic          sem_dec;
  logic [DW-1:0] xf_out;

  logic [DW-1:0] ctl0, ctl1, len;
  logic          mode_bad, len_bad;

  assign ctl0 = desc_q[W_CTL0];
  assign ctl1 = desc_q[W_CTL1];
  assign len  = desc_q[W_LEN];

  assign len_bad  = (len[BLK_BITS-1:0] != '0);
  assign mode_bad = ctl0[C0_CIPHER] && ctl0[C0_OTK] &&
                    (ctl0[C0_PLKEY] || (ctl1[15:8] != 8'hFF));

  dchain_sem #(.SEM_W(SEM_W), .DW(DW)) u_sem (
    .clk     (clk),
    .rst     (rst),
    .add_we  (cfg_we && (cfg_sel == CFG_SEM)),
    .add_val (cfg_wdata),
    .dec     (sem_dec),
    .count   (sem_count)
  );

  dchain_status #(.DW(DW)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .raise      (err_raise),
    .code       (err_code),
    .flags      (err_flags),
    .clr_we     (cfg_we && (cfg_sel == CFG_CLR)),
    .clr_mask   (cfg_wdata),
    .status     (chan_status),
    .err_active (err_active)
  );

  dchain_xform #(.DW(DW), .KEY(XOR_KEY)) u_xf (
    .en   (ctl0[C0_CIPHER]),
    .din  (mem_rdata),
    .dout (xf_out)
  );

  // error detection and semaphore consumption, decoded from the FSM state
  always_comb begin
    err_raise = 1'b0;
    err_code  = '0;
    err_flags = '0;
    sem_dec   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!err_active && (sem_count != '0) && !chain_ok) begin
          err_raise = 1'b1;
          err_code  = ERR_NO_CHAIN;
          err_flags = FLG_SETUP;
        end
      end
      ST_CHECK: begin
        if (len_bad) begin
          err_raise = 1'b1;
          err_code  = ERR_PAYLOAD;
          err_flags = FLG_PACKET;
        end else if (mode_bad) begin
          err_raise = 1'b1;
          err_code  = ERR_MODE;
          err_flags = FLG_SETUP;
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          sem_dec = ctl0[C0_SEMDEC];
          if (ctl0[C0_CHAIN] && (desc_q[W_NEXT] == '0)) begin
            err_raise = 1'b1;
            err_code  = ERR_NEXT_ZERO;
            err_flags = FLG_SETUP;
          end
        end
      end
      default: ;
    endcase
  end

  // descriptor buffer, written word by word during the fetch
  always_ff @(posedge clk) begin
    if (state == ST_FETCH && mem_ack) desc_q[widx] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      chain_ok  <= 1'b0;
      widx      <= '0;
      remain    <= '0;
      offs      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done_irq  <= 1'b0;
    end else begin
      done_irq <= err_raise ||
                  (state == ST_WBACK && mem_ack && ctl0[C0_IRQ]);
      if (cfg_we && (cfg_sel == CFG_PTR)) begin
        cur_ptr  <= AW'(cfg_wdata);
        chain_ok <= 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (!err_active && (sem_count != '0) && chain_ok) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_ptr;
            widx     <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (widx == 3'(FETCH_WORDS - 1)) begin
              mem_req <= 1'b0;
              state   <= ST_CHECK;
            end else begin
              widx     <= widx + 3'd1;
              mem_addr <= mem_addr + AW'(BPW);
            end
          end
        end
        ST_CHECK: begin
          if (err_raise) begin
            state <= ST_IDLE;
          end else if (len == '0) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr + AW'(WB_OFS);
            mem_wdata <= DW'(1);
            state     <= ST_WBACK;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= AW'(desc_q[W_SRC]);
            offs     <= '0;
            remain   <= len >> WORD_SHIFT;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_we    <= 1'b1;
            mem_addr  <= AW'(desc_q[W_DST]) + offs;
            mem_wdata <= xf_out;
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (remain == DW'(1)) begin
              mem_addr  <= cur_ptr + AW'(WB_OFS);
              mem_wdata <= DW'(1);
              state     <= ST_WBACK;
            end else begin
              remain   <= remain - DW'(1);
              offs     <= offs + AW'(BPW);
              mem_we   <= 1'b0;
              mem_addr <= AW'(desc_q[W_SRC]) + offs + AW'(BPW);
              state    <= ST_READ;
            end
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (ctl0[C0_CHAIN] && (desc_q[W_NEXT] != '0)) begin
              cur_ptr <= AW'(desc_q[W_NEXT]);
            end else begin
              chain_ok <= 1'b0;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/dchain_engine_chk.sv
module dchain_engine_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_ack,
  input logic [DW-1:0]    chan_status,
  input logic [SEM_W-1:0] sem_count,
  input logic             busy
);
  // R12: request fields hold until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R11: a latched error keeps the idle channel off the memory port
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ((chan_status[23:16] != 8'd0) && !mem_req) |=> !mem_req);

  // R2: no fetch starts from idle with an empty semaphore
  p_no_start_empty_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && !busy && (sem_count == '0)) |=> !mem_req);

  // R3: the semaphore only falls at a write acknowledge
  p_sem_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_ack && mem_we) |=> (sem_count >= $past(sem_count)));

  // R3: a fall is exactly one credit
  p_sem_step_r3: assert property (@(posedge clk) disable iff (rst)
    (sem_count < $past(sem_count)) |-> (($past(sem_count) - sem_count) == SEM_W'(1)));

  // R8: only defined error codes appear
  p_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
    (chan_status[23:16] inside {8'd0, 8'd1, 8'd2, 8'd4, 8'd5}));
endmodule

bind dchain_engine dchain_engine_chk #(.AW(AW), .DW(DW), .SEM_W(SEM_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .chan_status (chan_status),
  .sem_count   (sem_count),
  .busy        (busy)
);

// File: tb/dchain_engine_tb_top.sv
module dchain_engine_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] KEY        = 32'h5A5A_A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] chan_status;
  logic [7:0]  sem_count;
  logic        busy, done_irq;

  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_data = '0;
  logic [31:0] mem [0:255];

  int checks = 0, errors = 0, irq_cnt = 0, viol = 0;
  bit finished = 0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_engine #(.XOR_KEY(KEY)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .chan_status(chan_status),
    .sem_count(sem_count), .busy(busy), .done_irq(done_irq)
  );

  // memory model: one request at a time, acknowledged on the next edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (tb_we) mem[tb_addr[9:2]] <= tb_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[9:2]];
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done_irq) irq_cnt++;
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol++;
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mput(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] base, nxt, c0, c1, src, dst, len);
    mput(base + 0, nxt);  mput(base + 4, c0);   mput(base + 8, c1);
    mput(base + 12, src); mput(base + 16, dst); mput(base + 20, len);
    mput(base + 24, 32'h0); mput(base + 28, 32'h0);
  endtask

  task automatic settle();
    int quiet = 0;
    for (int n = 0; n < 4000 && quiet < 6; n++) begin
      @(negedge clk);
      if (busy || mem_req) quiet = 0;
      else quiet++;
    end
  endtask

  task automatic t_reset();
    chk("R13 status", chan_status, 32'h0);
    chk("R13 sem", {24'h0, sem_count}, 32'h0);
    chk("R13 irq", {31'h0, done_irq}, 32'h0);
    chk("R13 busy", {31'h0, busy}, 32'h0);
    chk("R13 req", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_plain_copy();
    int i0 = irq_cnt;
    for (int i = 0; i < 8; i++) mput(32'h100 + 4*i, 32'hC0DE_0000 + i);
    put_desc(32'h000, 32'h0, 32'h3, 32'h0, 32'h100, 32'h200, 32);
    cfg(2'd0, 32'h000);
    repeat (10) @(negedge clk);
    chk("R2 idle without credit", {31'h0, busy | mem_req}, 32'h0);
    chk("R2 status untouched", rd(32'h01C), 32'h0);
    cfg(2'd1, 32'd1);
    settle();
    for (int i = 0; i < 8; i++) chk("R4 copy word", rd(32'h200 + 4*i), 32'hC0DE_0000 + i);
    chk("R4 no overrun", rd(32'h220), 32'h0);
    chk("R5 status word", rd(32'h01C), 32'h1);
    chk("R3 credit used", {24'h0, sem_count}, 32'h0);
    chk("R10 one pulse", irq_cnt - i0, 32'd1);
    chk("R11 clean status", chan_status, 32'h0);
    chk("R12 handshake", viol, 32'd0);
  endtask

  task automatic t_chain_xor();
    int i0 = irq_cnt;
    for (int i = 0; i < 8; i++) mput(32'h140 + 4*i, 32'h1111_0000 + 32'h31*i);
    put_desc(32'h040, 32'h060, 32'h27, 32'h0, 32'h140, 32'h240, 16);
    put_desc(32'h060, 32'h000, 32'h23, 32'h0, 32'h150, 32'h250, 16);
    cfg(2'd0, 32'h040);
    cfg(2'd1, 32'd2);
    settle();
    for (int i = 0; i < 8; i++)
      chk("R4 R6 xor word", rd(32'h240 + 4*i), (32'h1111_0000 + 32'h31*i) ^ KEY);
    chk("R1 R5 first status", rd(32'h05C), 32'h1);
    chk("R6 second status", rd(32'h07C), 32'h1);
    chk("R3 two credits used", {24'h0, sem_count}, 32'h0);
    chk("R10 two pulses", irq_cnt - i0, 32'd2);
  endtask

  task automatic t_no_chain_gate();
    int i0 = irq_cnt;
    for (int i = 0; i < 4; i++) mput(32'h160 + 4*i, 32'hABC0_0000 + i);
    put_desc(32'h080, 32'h0, 32'h3, 32'h0, 32'h160, 32'h260, 16);
    cfg(2'd1, 32'd1);
    settle();
    chk("R6 no chain error", chan_status, 32'h0002_0004);
    chk("R10 error pulse", irq_cnt - i0, 32'd1);
    cfg(2'd0, 32'h080);
    repeat (20) @(negedge clk);
    chk("R11 ignored while error", rd(32'h09C), 32'h0);
    chk("R11 no data while error", rd(32'h260), 32'h0);
    chk("R11 credit kept", {24'h0, sem_count}, 32'h1);
    cfg(2'd2, 32'h0000_00FF);
    repeat (20) @(negedge clk);
    chk("R11 partial clear", chan_status, 32'h0002_0000);
    chk("R11 still ignored", rd(32'h09C), 32'h0);
    cfg(2'd2, 32'h00FF_0000);
    settle();
    chk("R11 runs after clear", rd(32'h09C), 32'h1);
    chk("R11 data after clear", rd(32'h26C), 32'hABC0_0003);
    chk("R11 status clear", chan_status, 32'h0);
  endtask

  task automatic drain_with_e();
    mput(32'h0DC, 32'h0);
    cfg(2'd0, 32'h0C0);
    cfg(2'd2, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_no_dec();
    int i0 = irq_cnt;
    for (int i = 0; i < 4; i++) mput(32'h170 + 4*i, 32'h7700_0000 + i);
    put_desc(32'h0A0, 32'h0, 32'h1, 32'h0, 32'h170, 32'h270, 16);
    put_desc(32'h0C0, 32'h0, 32'h2, 32'h0, 32'h0, 32'h0, 0);
    cfg(2'd0, 32'h0A0);
    cfg(2'd1, 32'd1);
    settle();
    chk("R3 done without decrement", rd(32'h0BC), 32'h1);
    chk("R3 credit unchanged", {24'h0, sem_count}, 32'h1);
    chk("R6 leftover credit error", chan_status, 32'h0002_0004);
    chk("R10 done plus error", irq_cnt - i0, 32'd2);
    i0 = irq_cnt;
    drain_with_e();
    chk("R4 zero length done", rd(32'h0DC), 32'h1);
    chk("R3 decrement only", {24'h0, sem_count}, 32'h0);
    chk("R10 no pulse without bit", irq_cnt - i0, 32'd0);
  endtask

  task automatic t_next_zero();
    int i0 = irq_cnt;
    put_desc(32'h0E0, 32'h0, 32'h7, 32'h0, 32'h100, 32'h2C0, 16);
    cfg(2'd0, 32'h0E0);
    cfg(2'd1, 32'd1);
    settle();
    chk("R7 written back", rd(32'h0FC), 32'h1);
    chk("R7 data moved", rd(32'h2C0), 32'hC0DE_0000);
    chk("R7 error code", chan_status, 32'h0001_0004);
    chk("R7 credit used", {24'h0, sem_count}, 32'h0);
    chk("R10 single pulse", irq_cnt - i0, 32'd1);
    cfg(2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_payload_err();
    int i0 = irq_cnt;
    mput(32'h280, 32'hDEAD_BEEF);
    put_desc(32'h300, 32'h0, 32'h3, 32'h0, 32'h180, 32'h280, 20);
    cfg(2'd0, 32'h300);
    cfg(2'd1, 32'd1);
    settle();
    chk("R8 payload code", chan_status, 32'h0004_0008);
    chk("R8 no write back", rd(32'h31C), 32'h0);
    chk("R8 no data", rd(32'h280), 32'hDEAD_BEEF);
    chk("R8 credit kept", {24'h0, sem_count}, 32'h1);
    chk("R10 error pulse", irq_cnt - i0, 32'd1);
    drain_with_e();
    chk("R8 drained", {24'h0, sem_count}, 32'h0);
  endtask

  task automatic t_mode_err();
    int i0 = irq_cnt;
    for (int i = 0; i < 4; i++) mput(32'h190 + 4*i, 32'h0F0F_0000 + i);
    mput(32'h290, 32'hDEAD_BEEF);
    put_desc(32'h320, 32'h0, 32'h421, 32'h0, 32'h190, 32'h290, 16);
    cfg(2'd0, 32'h320);
    cfg(2'd1, 32'd1);
    settle();
    chk("R9 mode code", chan_status, 32'h0005_0004);
    chk("R9 no data", rd(32'h290), 32'hDEAD_BEEF);
    chk("R10 error pulse", irq_cnt - i0, 32'd1);
    mput(32'h324, 32'h423);
    mput(32'h328, 32'h0000_FF00);
    cfg(2'd2, 32'hFFFF_FFFF);
    settle();
    for (int i = 0; i < 4; i++) chk("R9 key select ok", rd(32'h290 + 4*i), (32'h0F0F_0000 + i) ^ KEY);
    chk("R9 status word", rd(32'h33C), 32'h1);
    chk("R9 credit used", {24'h0, sem_count}, 32'h0);
  endtask

  task automatic t_saturate();
    int i0 = irq_cnt;
    cfg(2'd1, 32'd1);
    settle();
    chk("R6 error before adds", chan_status, 32'h0002_0004);
    cfg(2'd1, 32'd200);
    cfg(2'd1, 32'd100);
    @(negedge clk);
    chk("R2 saturates", {24'h0, sem_count}, 32'd255);
    chk("R11 no fetch while error", irq_cnt - i0, 32'd1);
    chk("R12 handshake end", viol, 32'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain_copy();
    t_chain_xor();
    t_no_chain_gate();
    t_no_dec();
    t_next_zero();
    t_payload_err();
    t_mode_err();
    t_saturate();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule